// File: doc/BRIEF.md
# Hardware cursor overlay generator

This block lays a 64 by 64 cursor, two bits per cursor pixel, over a live stream of 30-bit RGB pixels. Each accepted beat carries the pixel together with its screen column, its line and the field flag. The block works out whether that pixel falls inside the cursor square and reads the matching 2-bit code from an on-block image store. It then passes the pixel through, replaces it with one of two cursor colours, or inverts it bit by bit. Which of these happens depends on the code and on the selected cursor mode.

The cursor position is a pair of signed 16-bit values measured from the top-left corner. A negative value pushes the cursor partly or wholly off the left or top edge. Position is captured once per frame or field, on the beat at column 0 of line 0. In interlaced operation the line input counts lines within the current field, and the block rebuilds the frame line as twice that count plus the field flag. A field of parity 0 therefore carries even frame lines. The image store is loaded through a plain byte write port. A read in the same cycle as a write to the same byte returns the old content.

Both stream edges use valid/ready. A beat is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being emptied in the same cycle. An output beat stays valid, with its data unchanged, until `m_ready` takes it. The result of an accepted beat appears on the output one cycle later.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high.
- R2: A beat accepted in cycle n is presented on the output in cycle n+1. While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_valid` and `m_pix` hold their values.
- R3: A pixel is inside the cursor when 0 <= X-CX < 64 and 0 <= L-CY < 64, where L is the frame line. A pixel outside the cursor leaves the block unchanged.
- R4: The cursor pixel at cursor row r, column c is held in image byte r*16 + c/4, at bits [2k+1:2k] with k = c mod 4.
- R5: In mode 0 (two-colour mode), codes 00 and 01 pass the pixel, code 10 gives colour 1 and code 11 gives colour 2.
- R6: In mode 1 (inverting mode), code 00 gives colour 1, code 01 gives colour 2, code 10 passes the pixel and code 11 gives the bitwise complement of all 30 pixel bits.
- R7: With `cur_enable` low, every pixel passes unchanged.
- R8: Negative positions clip the cursor at the left and top edges. Only the part of the square that lies on screen is drawn, using the matching image rows and columns.
- R9: With `cur_interlace` high, the frame line is L = 2*`s_y` + `s_field`. With `cur_interlace` low, L = `s_y`.
- R10: `cur_x` and `cur_y` are taken on the accepted beat with `s_x`=0 and `s_y`=0, and they apply from that beat onward. Changes at other times have no effect until the next such beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take an input beat |
| s_pix | input | 30 | Input pixel, 10 bits each of R, G, B |
| s_x | input | 12 | Screen column of the input pixel |
| s_y | input | 12 | Line of the input pixel (field line when interlaced) |
| s_field | input | 1 | Field parity, 1 = odd field |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream takes the output beat |
| m_pix | output | 30 | Output pixel |
| cur_x | input | 16 | Cursor column, two's complement |
| cur_y | input | 16 | Cursor frame line, two's complement |
| cur_color1 | input | 30 | Cursor colour 1 |
| cur_color2 | input | 30 | Cursor colour 2 |
| cur_enable | input | 1 | Overlay on |
| cur_mode | input | 1 | 0 = two-colour mode, 1 = inverting mode |
| cur_interlace | input | 1 | Interlaced line numbering |
| img_we | input | 1 | Image byte write strobe |
| img_addr | input | 10 | Image byte address |
| img_wdata | input | 8 | Image byte data |

## Verification
The hardest case to reach is the interlaced line mapping when the cursor line is odd. Here cursor row 0 must come from the odd field and row 1 from the even field. The result is only correct if the position capture, the field flag and the line doubling all line up. The stimulus runs both fields against the same odd cursor line and then again against an even one. During these runs, random gaps on `s_valid` and random back-pressure on `m_ready` keep the pipeline stalling. A separate frame changes `cur_x` and `cur_y` partway through, after the capture beat, so that any use of the live position value would show up as a mismatch.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  typedef enum logic {
    CUR_MODE_TWO_COLOR = 1'b0,
    CUR_MODE_INVERT    = 1'b1
  } cur_mode_e;

  localparam int unsigned CODE_W = 2;
  localparam int unsigned PIX_PER_BYTE_LOG2 = 2;
endpackage

// File: rtl/cursor_geom.sv
module cursor_geom #(
  parameter int unsigned COORD_W  = 12,
  parameter int unsigned POS_W    = 16,
  parameter int unsigned DIM_LOG2 = 6
) (
  input  logic [COORD_W-1:0]  x,
  input  logic [COORD_W-1:0]  y,
  input  logic                field,
  input  logic                interlace,
  input  logic [POS_W-1:0]    cx,
  input  logic [POS_W-1:0]    cy,
  output logic                hit,
  output logic [DIM_LOG2-1:0] row,
  output logic [DIM_LOG2-1:0] col
);
  localparam int unsigned LW = COORD_W + 1;
  localparam int unsigned DW = ((LW > POS_W) ? LW : POS_W) + 2;

  logic [LW-1:0] line_full;
  logic signed [DW-1:0] dx, dy;
  logic in_x, in_y;

  // frame line: doubled field line plus parity when interlaced
  assign line_full = interlace ? {y, field} : {1'b0, y};

  assign dx = $signed({{(DW-COORD_W){1'b0}}, x}) - $signed({{(DW-POS_W){cx[POS_W-1]}}, cx});
  assign dy = $signed({{(DW-LW){1'b0}}, line_full}) - $signed({{(DW-POS_W){cy[POS_W-1]}}, cy});

  // inside when the offset lies in [0, 2**DIM_LOG2): all upper bits zero
  assign in_x = (dx[DW-1:DIM_LOG2] == '0);
  assign in_y = (dy[DW-1:DIM_LOG2] == '0);
  assign hit  = in_x && in_y;
  assign col  = dx[DIM_LOG2-1:0];
  assign row  = dy[DIM_LOG2-1:0];
endmodule

// File: rtl/cursor_image_mem.sv
module cursor_image_mem
  import cursor_pkg::*;
#(
  parameter int unsigned DIM_LOG2 = 6,
  localparam int unsigned AW = 2*DIM_LOG2 - PIX_PER_BYTE_LOG2,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [DIM_LOG2-1:0] rd_row,
  input  logic [DIM_LOG2-1:0] rd_col,
  output logic [CODE_W-1:0]   rd_code
);
  logic [7:0] store [DEPTH];
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_byte;
  logic [PIX_PER_BYTE_LOG2-1:0] lane;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // bytes run along a row, rows run down the image
  assign rd_addr = {rd_row, rd_col[DIM_LOG2-1:PIX_PER_BYTE_LOG2]};
  assign lane    = rd_col[PIX_PER_BYTE_LOG2-1:0];
  assign rd_byte = store[rd_addr];

  always_comb begin
    rd_code = '0;
    for (int k = 0; k < (1 << PIX_PER_BYTE_LOG2); k++) begin
      if (lane == k[PIX_PER_BYTE_LOG2-1:0]) rd_code = rd_byte[k*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
#(
  parameter int unsigned PIX_W = 30
) (
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [PIX_W-1:0]  color1,
  input  logic [PIX_W-1:0]  color2,
  input  logic [CODE_W-1:0] code,
  input  cur_mode_e         mode,
  input  logic              active,
  output logic [PIX_W-1:0]  pix_out
);
  always_comb begin
    pix_out = pix_in;
    if (active) begin
      unique case (mode)
        CUR_MODE_TWO_COLOR: begin
          case (code)
            2'b10:   pix_out = color1;
            2'b11:   pix_out = color2;
            default: pix_out = pix_in;
          endcase
        end
        CUR_MODE_INVERT: begin
          case (code)
            2'b00:   pix_out = color1;
            2'b01:   pix_out = color2;
            2'b11:   pix_out = ~pix_in;
            default: pix_out = pix_in;
          endcase
        end
        default: pix_out = pix_in;
      endcase
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int unsigned PIX_W    = 30,
  parameter int unsigned COORD_W  = 12,
  parameter int unsigned POS_W    = 16,
  parameter int unsigned DIM_LOG2 = 6,
  localparam int unsigned IMG_AW  = 2*DIM_LOG2 - PIX_PER_BYTE_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [PIX_W-1:0]   s_pix,
  input  logic [COORD_W-1:0] s_x,
  input  logic [COORD_W-1:0] s_y,
  input  logic               s_field,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [PIX_W-1:0]   m_pix,
  input  logic [POS_W-1:0]   cur_x,
  input  logic [POS_W-1:0]   cur_y,
  input  logic [PIX_W-1:0]   cur_color1,
  input  logic [PIX_W-1:0]   cur_color2,
  input  logic               cur_enable,
  input  logic               cur_mode,
  input  logic               cur_interlace,
  input  logic               img_we,
  input  logic [IMG_AW-1:0]  img_addr,
  input  logic [7:0]         img_wdata
);
  logic accept, frame_start;
  logic [POS_W-1:0] cx_q, cy_q, cx_use, cy_use;
  logic hit;
  logic [DIM_LOG2-1:0] row, col;
  logic [CODE_W-1:0] code;
  logic [PIX_W-1:0] blend_pix;
  logic [PIX_W-1:0] out_pix_q;
  logic out_valid_q;

  assign s_ready     = !out_valid_q || m_ready;
  assign accept      = s_valid && s_ready;
  assign frame_start = (s_x == '0) && (s_y == '0);

  // the capture beat already uses the new position
  assign cx_use = frame_start ? cur_x : cx_q;
  assign cy_use = frame_start ? cur_y : cy_q;

  cursor_geom #(
    .COORD_W(COORD_W), .POS_W(POS_W), .DIM_LOG2(DIM_LOG2)
  ) u_geom (
    .x(s_x), .y(s_y), .field(s_field), .interlace(cur_interlace),
    .cx(cx_use), .cy(cy_use), .hit(hit), .row(row), .col(col)
  );

  cursor_image_mem #(.DIM_LOG2(DIM_LOG2)) u_mem (
    .clk(clk), .wr_en(img_we), .wr_addr(img_addr), .wr_data(img_wdata),
    .rd_row(row), .rd_col(col), .rd_code(code)
  );

  cursor_blend #(.PIX_W(PIX_W)) u_blend (
    .pix_in(s_pix), .color1(cur_color1), .color2(cur_color2),
    .code(code), .mode(cur_mode_e'(cur_mode)), .active(hit && cur_enable),
    .pix_out(blend_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx_q        <= '0;
      cy_q        <= '0;
      out_pix_q   <= '0;
      out_valid_q <= 1'b0;
    end else begin
      if (accept) begin
        out_pix_q   <= blend_pix;
        out_valid_q <= 1'b1;
        if (frame_start) begin
          cx_q <= cur_x;
          cy_q <= cur_y;
        end
      end else if (m_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign m_valid = out_valid_q;
  assign m_pix   = out_pix_q;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int unsigned PIX_W   = 30,
  parameter int unsigned COORD_W = 12,
  parameter int unsigned POS_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic [PIX_W-1:0]   s_pix,
  input logic [COORD_W-1:0] s_x,
  input logic [COORD_W-1:0] s_y,
  input logic               m_valid,
  input logic               m_ready,
  input logic [PIX_W-1:0]   m_pix,
  input logic [POS_W-1:0]   cur_x,
  input logic               cur_enable
);
  logic acc_start;
  assign acc_start = s_valid && s_ready && (s_x == '0) && (s_y == '0);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix)));

  // R2
  stall_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R2
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  // R7
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !cur_enable) |=> (m_pix == $past(s_pix)));

  // R3
  right_of_origin_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && ($signed(cur_x) > 0)) |=> (m_pix == $past(s_pix)));

  // R8
  far_left_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && ($signed(cur_x) <= -64)) |=> (m_pix == $past(s_pix)));
endmodule

bind cursor_overlay cursor_overlay_chk #(
  .PIX_W(PIX_W), .COORD_W(COORD_W), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_pix(s_pix), .s_x(s_x), .s_y(s_y), .m_valid(m_valid),
  .m_ready(m_ready), .m_pix(m_pix), .cur_x(cur_x), .cur_enable(cur_enable)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [29:0] s_pix = '0;
  logic [11:0] s_x = '0;
  logic [11:0] s_y = '0;
  logic        s_field = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [29:0] m_pix;
  logic [15:0] cur_x = '0;
  logic [15:0] cur_y = '0;
  logic [29:0] cur_color1 = 30'h2A5_0F3C7;
  logic [29:0] cur_color2 = 30'h0C3_39A55;
  logic        cur_enable = 1'b0;
  logic        cur_mode = 1'b0;
  logic        cur_interlace = 1'b0;
  logic        img_we = 1'b0;
  logic [9:0]  img_addr = '0;
  logic [7:0]  img_wdata = '0;

  int checks = 0;
  int errors = 0;
  int bmem [1024];
  int lat_x = 0, lat_y = 0;
  string frame_tag = "";
  logic [29:0] exp_q [$];
  string tag_q [$];
  bit stall_prev = 0;
  logic [29:0] stall_pix;
  bit done = 0;

  always #4 clk = ~clk;

  cursor_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_pix(s_pix), .s_x(s_x), .s_y(s_y), .s_field(s_field),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix),
    .cur_x(cur_x), .cur_y(cur_y), .cur_color1(cur_color1), .cur_color2(cur_color2),
    .cur_enable(cur_enable), .cur_mode(cur_mode), .cur_interlace(cur_interlace),
    .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata)
  );

  task automatic check(bit ok, string req, logic [29:0] act, logic [29:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int code_at(int r, int c);
    return (bmem[r*16 + c/4] >> (2*(c%4))) & 3;
  endfunction

  // behavioural model of one accepted beat
  function automatic logic [29:0] model(logic [29:0] p, int x, int y, bit fld, output string tag);
    int ln, dx, dy, cd;
    ln = cur_interlace ? (2*y + fld) : y;
    dx = x - lat_x;
    dy = ln - lat_y;
    if (!cur_enable) begin tag = "R7"; return p; end
    if (frame_tag != "") tag = frame_tag;
    else if (lat_x < 0 || lat_y < 0) tag = "R8";
    else if (cur_interlace) tag = "R9";
    else if (dx < 0 || dx > 63 || dy < 0 || dy > 63) tag = "R3";
    else tag = cur_mode ? "R4 R6" : "R4 R5";
    if (dx < 0 || dx > 63 || dy < 0 || dy > 63) return p;
    cd = code_at(dy, dx);
    if (!cur_mode) begin
      if (cd == 2) return cur_color1;
      if (cd == 3) return cur_color2;
      return p;
    end
    if (cd == 0) return cur_color1;
    if (cd == 1) return cur_color2;
    if (cd == 3) return ~p;
    return p;
  endfunction

  // one clock: inputs already set after a falling edge
  task automatic step(output bit taken);
    string tg;
    logic [29:0] e;
    m_ready = ($urandom % 4) != 0;
    #1;
    if (stall_prev) check(m_valid && (m_pix == stall_pix), "R2 stall hold", m_pix, stall_pix);
    stall_prev = m_valid && !m_ready;
    stall_pix  = m_pix;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected output", m_pix, '0);
      else begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(m_pix == e, tg, m_pix, e);
      end
    end
    taken = s_valid && s_ready;
    if (taken) begin
      if (s_x == 0 && s_y == 0) begin
        lat_x = $signed(cur_x);
        lat_y = $signed(cur_y);
      end
      e = model(s_pix, int'(s_x), int'(s_y), s_field, tg);
      exp_q.push_back(e);
      tag_q.push_back(tg);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(int w, int h, bit fld, int cx, int cy, bit mid_move);
    bit tk;
    cur_x = 16'(cx);
    cur_y = 16'(cy);
    s_field = fld;
    for (int y = 0; y < h; y++) begin
      if (mid_move && y == 1) begin
        cur_x = 16'(cx + 17);
        cur_y = 16'(cy - 9);
      end
      for (int x = 0; x < w; x++) begin
        s_x = 12'(x);
        s_y = 12'(y);
        s_pix = 30'($urandom);
        do begin
          s_valid = ($urandom % 5) != 0;
          step(tk);
        end while (!tk);
      end
    end
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit tk;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(m_valid == 1'b0, "R1 m_valid", 30'(m_valid), 30'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid == 1'b0 && s_ready == 1'b1, "R1 idle after reset", {28'd0, m_valid, s_ready}, 30'd1);

    // load the image through the byte port
    for (int a = 0; a < 1024; a++) begin
      bmem[a] = ((a * 37) ^ (a >> 3) ^ 8'h5A) & 8'hFF;
      img_we = 1'b1;
      img_addr = 10'(a);
      img_wdata = 8'(bmem[a]);
      @(negedge clk);
    end
    img_we = 1'b0;

    cur_enable = 1'b1;
    cur_mode = 1'b0;
    run_frame(72, 72, 0, 5, 3, 0);          // R3 R4 R5
    cur_mode = 1'b1;
    run_frame(72, 72, 0, 6, 4, 0);          // R4 R6
    cur_enable = 1'b0;
    run_frame(40, 40, 0, 0, 0, 0);          // R7
    cur_enable = 1'b1;
    run_frame(48, 48, 0, -20, -33, 0);      // R8
    run_frame(24, 24, 0, -64, 0, 0);        // R8 fully off
    cur_interlace = 1'b1;
    run_frame(48, 36, 0, 3, 7, 0);          // R9 odd Y, even field
    run_frame(48, 36, 1, 3, 7, 0);          // R9 odd Y, odd field
    cur_mode = 1'b0;
    run_frame(48, 36, 0, 3, 12, 0);         // R9 even Y
    run_frame(48, 36, 1, 3, 12, 0);
    cur_interlace = 1'b0;
    cur_mode = 1'b1;
    frame_tag = "R10";
    run_frame(72, 72, 0, 2, 1, 1);          // R10 mid-frame move ignored
    frame_tag = "";

    // drain
    s_valid = 1'b0;
    for (int i = 0; i < 8; i++) step(tk);
    check(exp_q.size() == 0, "R2 all beats delivered", 30'(exp_q.size()), 30'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule